// File: doc/BRIEF.md
# Fractional Frequency Computation Unit

This unit turns the raw counts of a finished one-second gate into a frequency with a millihertz part. For each of two inputs, called master and slave, it takes three counts. The first is the number of rising edges counted inside the gate. The other two are the reference-clock cycles that fall in the partial input cycles at the two ends of the gate.

From the edge count it derives how many reference cycles make up one input cycle. It then folds the two boundary counts into the whole-cycle total: either they add up to one full input cycle, or one cycle is borrowed back from the edge count. The leftover reference cycles are scaled into millihertz with integer arithmetic only. The unit reports both results and the master-minus-slave difference as a magnitude with a separate sign bit.

A single pulse on `start_i` captures all six counts. One shared restoring divider runs the two divisions per channel, master first and then slave. When every output is valid, `done_o` pulses for one cycle, and the outputs hold their values until the next pulse.

Top module: `freq_frac_calc`

## Requirements
- R1: The cycles per input period Ni equals REF_HZ (default 250,000,000) divided by the edge count, truncated to an integer.
- R2: With S = lead + trail: if S >= Ni, the leftover Nnet is S - Ni and the whole-hertz result equals the edge count; otherwise Nnet is S and the whole-hertz result is the edge count minus one.
- R3: The millihertz result is Nnet multiplied by the truncated quotient 1000 / Ni (for example, an edge count of 10,000,000 gives Ni = 25 and 40 mHz per leftover cycle).
- R4: With C = hertz*1000 + millihertz for each channel, `diff_neg_o` is 1 exactly when C(master) < C(slave), and `diff_mag_o` is |C(master) - C(slave)|.
- R5: If either channel has an edge count of zero, or an Ni of zero (edge count above REF_HZ), `err_o` is 1 at done and every result output, the sign included, is zero.
- R6: If Nnet is still >= Ni after the fold of R2, the run is treated as in R5: `err_o` is 1 and every result output is zero.
- R7: `busy_o` is 1 from the cycle after an accepted start through the cycle in which `done_o` is 1. A start that arrives while `busy_o` is 1, including in the done cycle, is ignored and produces no further done pulse.
- R8: `done_o` is a single-cycle pulse, and all result outputs keep their values between done pulses.
- R9: After reset, `busy_o`, `done_o`, `err_o` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Captures the six counts when the unit is idle |
| m_cycles_i | input | 32 | Master edge count inside the gate |
| m_lead_i | input | 32 | Master reference cycles before the first edge |
| m_trail_i | input | 32 | Master reference cycles after the last edge |
| s_cycles_i | input | 32 | Slave edge count inside the gate |
| s_lead_i | input | 32 | Slave reference cycles before the first edge |
| s_trail_i | input | 32 | Slave reference cycles after the last edge |
| busy_o | output | 1 | A computation is in progress |
| done_o | output | 1 | One-cycle pulse: results are valid |
| err_o | output | 1 | The last run hit a zero-count or overflow fault |
| m_hz_o | output | 32 | Master whole hertz |
| m_mhz_o | output | 10 | Master millihertz |
| s_hz_o | output | 32 | Slave whole hertz |
| s_mhz_o | output | 10 | Slave millihertz |
| diff_mag_o | output | 42 | Magnitude of the master-minus-slave difference in millihertz |
| diff_neg_o | output | 1 | Sign of the difference, 1 for negative |

## Verification
The collision that matters is a new start arriving in the same cycle as the done pulse of the previous run. `busy_o` still covers that cycle, so the start must be dropped. The bench waits until it sees `done_o` high, then raises `start_i` with different operands in that same cycle. It judges the outcome in two ways: the scoreboard must receive no unexpected result over the following few hundred cycles, and `busy_o` must read low afterwards. A second, related case raises `start_i` in the middle of a run. The scoreboard then checks that the results still come from the operands captured first.

// File: rtl/ffc_pkg.sv
package ffc_pkg;

    localparam int CNT_W      = 32;
    localparam int FRAC_SCALE = 1000;
    localparam int FRAC_W     = $clog2(FRAC_SCALE);
    localparam int CMB_W      = CNT_W + FRAC_W;

    typedef struct packed {
        logic [CNT_W-1:0] cycles;
        logic [CNT_W-1:0] lead;
        logic [CNT_W-1:0] trail;
    } ffc_gate_t;

    typedef struct packed {
        logic [CNT_W-1:0]  hz;
        logic [FRAC_W-1:0] mhz;
    } ffc_result_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_NI,
        S_YI,
        S_FIN
    } ffc_state_e;

    // Whole hertz and millihertz merged into one millihertz count
    function automatic logic [CMB_W-1:0] ffc_combine(input ffc_result_t r);
        return CMB_W'(r.hz) * CMB_W'(FRAC_SCALE) + CMB_W'(r.mhz);
    endfunction

endpackage

// File: rtl/ffc_divider.sv
module ffc_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot
);
    localparam int CNTW = $clog2(W + 1);
    localparam int PW   = 2 * W;

    logic [W-1:0]    q_r, d_r, n_r;
    logic [W:0]      rem_r;
    logic [CNTW-1:0] cnt_r;
    logic            run_r;
    logic [W:0]      shifted, trial;

    assign shifted = {rem_r[W-1:0], q_r[W-1]};
    assign trial   = shifted - {1'b0, d_r};
    assign quot    = q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_r <= 1'b0;
            done  <= 1'b0;
            cnt_r <= '0;
            rem_r <= '0;
            q_r   <= '0;
            d_r   <= '0;
            n_r   <= '0;
        end else begin
            done <= 1'b0;
            if (go && !run_r) begin
                run_r <= 1'b1;
                cnt_r <= CNTW'(W);
                rem_r <= '0;
                q_r   <= dividend;
                n_r   <= dividend;
                d_r   <= divisor;
            end else if (run_r) begin
                if (!trial[W]) begin
                    rem_r <= trial;
                    q_r   <= {q_r[W-2:0], 1'b1};
                end else begin
                    rem_r <= shifted;
                    q_r   <= {q_r[W-2:0], 1'b0};
                end
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CNTW'(1)) begin
                    run_r <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    logic [PW-1:0] lo_prod, hi_prod;
    assign lo_prod = PW'(q_r) * PW'(d_r);
    assign hi_prod = lo_prod + PW'(d_r);

    // R1
    div_exact_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (lo_prod <= PW'(n_r)) && (PW'(n_r) < hi_prod));

endmodule

// File: rtl/ffc_diff.sv
module ffc_diff
    import ffc_pkg::*;
(
    input  ffc_result_t      master,
    input  ffc_result_t      slave,
    output logic [CMB_W-1:0] mag,
    output logic             neg
);
    logic [CMB_W-1:0]  a_v, b_v;
    logic signed [CMB_W:0] delta, flip;

    assign a_v   = ffc_combine(master);
    assign b_v   = ffc_combine(slave);
    assign delta = $signed({1'b0, a_v}) - $signed({1'b0, b_v});
    assign flip  = -delta;
    assign neg   = delta[CMB_W];
    assign mag   = neg ? flip[CMB_W-1:0] : delta[CMB_W-1:0];

endmodule

// File: rtl/freq_frac_calc.sv
module freq_frac_calc
    import ffc_pkg::*;
#(
    parameter int unsigned REF_HZ = 250_000_000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [CNT_W-1:0]    m_cycles_i,
    input  logic [CNT_W-1:0]    m_lead_i,
    input  logic [CNT_W-1:0]    m_trail_i,
    input  logic [CNT_W-1:0]    s_cycles_i,
    input  logic [CNT_W-1:0]    s_lead_i,
    input  logic [CNT_W-1:0]    s_trail_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic [CNT_W-1:0]    m_hz_o,
    output logic [FRAC_W-1:0]   m_mhz_o,
    output logic [CNT_W-1:0]    s_hz_o,
    output logic [FRAC_W-1:0]   s_mhz_o,
    output logic [CMB_W-1:0]    diff_mag_o,
    output logic                diff_neg_o
);
    localparam int NCH = 2;

    ffc_state_e       state_q;
    ffc_gate_t        gate_q [NCH];
    ffc_result_t      res_q  [NCH];
    logic             ch_q;
    logic             bad_q;
    logic [CNT_W-1:0] ni_q, net_q, whole_q;
    logic             div_go_q;
    logic [CNT_W-1:0] div_num_q, div_den_q;
    logic             div_done;
    logic [CNT_W-1:0] div_quot;

    ffc_divider #(.W(CNT_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go_q),
        .dividend (div_num_q),
        .divisor  (div_den_q),
        .done     (div_done),
        .quot     (div_quot)
    );

    // Fold of the boundary counts against the fresh Ni quotient
    ffc_gate_t        cur;
    logic [CNT_W:0]   sum_n, net_n;
    logic [CNT_W-1:0] whole_n;
    logic [FRAC_W-1:0] frac_n;

    assign cur   = gate_q[ch_q];
    assign sum_n = {1'b0, cur.lead} + {1'b0, cur.trail};

    always_comb begin
        if (sum_n >= {1'b0, div_quot}) begin
            net_n   = sum_n - {1'b0, div_quot};
            whole_n = cur.cycles;
        end else begin
            net_n   = sum_n;
            whole_n = cur.cycles - 1'b1;
        end
    end

    assign frac_n = FRAC_W'(net_q * div_quot);

    logic [CMB_W-1:0] dmag;
    logic             dneg;

    ffc_diff u_diff (
        .master (res_q[0]),
        .slave  (res_q[1]),
        .mag    (dmag),
        .neg    (dneg)
    );

    assign busy_o = (state_q != S_IDLE) || done_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            ch_q       <= 1'b0;
            bad_q      <= 1'b0;
            ni_q       <= '0;
            net_q      <= '0;
            whole_q    <= '0;
            div_go_q   <= 1'b0;
            div_num_q  <= '0;
            div_den_q  <= '0;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
            m_hz_o     <= '0;
            m_mhz_o    <= '0;
            s_hz_o     <= '0;
            s_mhz_o    <= '0;
            diff_mag_o <= '0;
            diff_neg_o <= 1'b0;
            for (int i = 0; i < NCH; i++) begin
                gate_q[i] <= '0;
                res_q[i]  <= '0;
            end
        end else begin
            div_go_q <= 1'b0;
            done_o   <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start_i && !done_o) begin
                    gate_q[0] <= '{cycles: m_cycles_i, lead: m_lead_i, trail: m_trail_i};
                    gate_q[1] <= '{cycles: s_cycles_i, lead: s_lead_i, trail: s_trail_i};
                    ch_q      <= 1'b0;
                    bad_q     <= 1'b0;
                    state_q   <= S_LOAD;
                end
                S_LOAD: begin
                    if (cur.cycles == '0) begin
                        bad_q   <= 1'b1;
                        state_q <= S_FIN;
                    end else begin
                        div_go_q  <= 1'b1;
                        div_num_q <= CNT_W'(REF_HZ);
                        div_den_q <= cur.cycles;
                        state_q   <= S_NI;
                    end
                end
                S_NI: if (div_done) begin
                    if (div_quot == '0 || net_n >= {1'b0, div_quot}) begin
                        bad_q   <= 1'b1;
                        state_q <= S_FIN;
                    end else begin
                        ni_q      <= div_quot;
                        net_q     <= net_n[CNT_W-1:0];
                        whole_q   <= whole_n;
                        div_go_q  <= 1'b1;
                        div_num_q <= CNT_W'(FRAC_SCALE);
                        div_den_q <= div_quot;
                        state_q   <= S_YI;
                    end
                end
                S_YI: if (div_done) begin
                    res_q[ch_q] <= '{hz: whole_q, mhz: frac_n};
                    if (ch_q) begin
                        state_q <= S_FIN;
                    end else begin
                        ch_q    <= 1'b1;
                        state_q <= S_LOAD;
                    end
                end
                S_FIN: begin
                    done_o  <= 1'b1;
                    err_o   <= bad_q;
                    state_q <= S_IDLE;
                    if (bad_q) begin
                        m_hz_o     <= '0;
                        m_mhz_o    <= '0;
                        s_hz_o     <= '0;
                        s_mhz_o    <= '0;
                        diff_mag_o <= '0;
                        diff_neg_o <= 1'b0;
                    end else begin
                        m_hz_o     <= res_q[0].hz;
                        m_mhz_o    <= res_q[0].mhz;
                        s_hz_o     <= res_q[1].hz;
                        s_mhz_o    <= res_q[1].mhz;
                        diff_mag_o <= dmag;
                        diff_neg_o <= dneg;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R2
    fold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_YI) |-> (whole_q <= cur.cycles) && ((cur.cycles - whole_q) <= 1));

    // R6
    nnet_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_YI) |-> (net_q < ni_q));

    // R5
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (m_hz_o == '0) && (s_hz_o == '0) && (diff_mag_o == '0) && !diff_neg_o);

    // R4
    sign_mag_chk: assert property (@(posedge clk) disable iff (rst)
        diff_neg_o |-> (diff_mag_o != '0));

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(diff_mag_o) && $stable(m_hz_o) && $stable(s_mhz_o));

endmodule

// File: tb/freq_frac_calc_bench.sv
module freq_frac_calc_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] m_cycles_i = '0, m_lead_i = '0, m_trail_i = '0;
    logic [31:0] s_cycles_i = '0, s_lead_i = '0, s_trail_i = '0;
    logic        busy_o, done_o, err_o, diff_neg_o;
    logic [31:0] m_hz_o, s_hz_o;
    logic [9:0]  m_mhz_o, s_mhz_o;
    logic [41:0] diff_mag_o;

    always #4 clk = ~clk;

    freq_frac_calc u_freq_frac_calc (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .m_cycles_i (m_cycles_i),
        .m_lead_i   (m_lead_i),
        .m_trail_i  (m_trail_i),
        .s_cycles_i (s_cycles_i),
        .s_lead_i   (s_lead_i),
        .s_trail_i  (s_trail_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .m_hz_o     (m_hz_o),
        .m_mhz_o    (m_mhz_o),
        .s_hz_o     (s_hz_o),
        .s_mhz_o    (s_mhz_o),
        .diff_mag_o (diff_mag_o),
        .diff_neg_o (diff_neg_o)
    );

    typedef struct {
        longint mh, mm, sh, sm, dm;
        bit     dn, er;
        string  req;
    } exp_t;

    exp_t   sb[$];
    exp_t   last_e;
    int     total = 0;
    int     bad   = 0;
    int     cyc   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void chan_model(input longint nc, input longint pre, input longint post,
                                       output longint hz, output longint mhz, output bit flt);
        longint ni, s, net;
        flt = 1'b0; hz = 0; mhz = 0;
        if (nc == 0) begin flt = 1'b1; return; end
        ni = 64'd250000000 / nc;
        if (ni == 0) begin flt = 1'b1; return; end
        s = pre + post;
        if (s >= ni) begin net = s - ni; hz = nc;     end
        else         begin net = s;      hz = nc - 1; end
        if (net >= ni) begin flt = 1'b1; hz = 0; return; end
        mhz = net * (1000 / ni);
    endfunction

    function automatic exp_t build(input longint mc, input longint ml, input longint mt,
                                   input longint sc, input longint sl, input longint st,
                                   input string req);
        exp_t   e;
        bit     f1, f2;
        longint a, b;
        chan_model(mc, ml, mt, e.mh, e.mm, f1);
        chan_model(sc, sl, st, e.sh, e.sm, f2);
        e.req = req;
        e.er  = f1 | f2;
        if (e.er) begin
            e.mh = 0; e.mm = 0; e.sh = 0; e.sm = 0; e.dm = 0; e.dn = 0;
        end else begin
            a = e.mh * 1000 + e.mm;
            b = e.sh * 1000 + e.sm;
            e.dn = (a < b);
            e.dm = e.dn ? b - a : a - b;
        end
        return e;
    endfunction

    // Monitor: pops one expected item per done pulse
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(m_hz_o == 32'(e.mh),     e.req, "m_hz",  m_hz_o,     e.mh);
                check(m_mhz_o == 10'(e.mm),    e.req, "m_mhz", m_mhz_o,    e.mm);
                check(s_hz_o == 32'(e.sh),     e.req, "s_hz",  s_hz_o,     e.sh);
                check(s_mhz_o == 10'(e.sm),    e.req, "s_mhz", s_mhz_o,    e.sm);
                check(diff_mag_o == 42'(e.dm), e.req, "diff_mag", diff_mag_o, e.dm);
                check(diff_neg_o == e.dn,      e.req, "diff_neg", diff_neg_o, e.dn);
                check(err_o == e.er,           e.req, "err",   err_o,      e.er);
            end
        end
    end

    task automatic drive(input longint mc, input longint ml, input longint mt,
                         input longint sc, input longint sl, input longint st);
        m_cycles_i = 32'(mc); m_lead_i = 32'(ml); m_trail_i = 32'(mt);
        s_cycles_i = 32'(sc); s_lead_i = 32'(sl); s_trail_i = 32'(st);
    endtask

    task automatic run(input longint mc, input longint ml, input longint mt,
                       input longint sc, input longint sl, input longint st,
                       input string req, input bit poke_mid);
        exp_t e;
        e = build(mc, ml, mt, sc, sl, st, req);
        sb.push_back(e);
        last_e = e;
        @(negedge clk);
        drive(mc, ml, mt, sc, sl, st);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R7: busy follows an accepted start
        check(busy_o == 1'b1, "R7", "busy after start", busy_o, 1);
        if (poke_mid) begin
            repeat (20) @(negedge clk);
            drive(5, 1, 1, 7, 2, 2);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        // R8: pulse ends, results held
        check(done_o == 1'b0, "R8", "done width", done_o, 0);
        check(m_hz_o == 32'(last_e.mh) && diff_mag_o == 42'(last_e.dm),
              "R8", "held m_hz", m_hz_o, last_e.mh);
        if (poke_mid) begin
            repeat (300) @(negedge clk);
            check(busy_o == 1'b0, "R7", "mid-run start ignored", busy_o, 0);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                check(1'b0, "R7", "watchdog", cyc, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(busy_o == 1'b0 && done_o == 1'b0, "R9", "busy/done", busy_o, 0);
        check(err_o == 1'b0 && diff_neg_o == 1'b0, "R9", "err/sign", err_o, 0);
        check(m_hz_o == '0 && s_hz_o == '0 && diff_mag_o == '0, "R9", "outputs", m_hz_o, 0);

        // R2 carry and borrow, R3 scaling, R4 positive difference
        run(10000000, 10, 20, 10000000, 3, 4, "R2 R3 R4 pos", 1'b0);
        // R4 negative difference
        run(10000000, 3, 4, 10000000, 10, 20, "R4 neg", 1'b0);
        // R2 boundary S == Ni and S == Ni-1
        run(10000000, 12, 13, 10000000, 24, 0, "R2 edge", 1'b0);
        // R1 non-integer quotient
        run(3000000, 50, 40, 7000001, 5, 9, "R1 trunc", 1'b0);
        // R1 low frequency, zero weight
        run(1000, 100000, 10, 1000, 100000, 10, "R1 R4 equal", 1'b0);
        // R5 zero edge count in slave
        run(10000000, 1, 1, 0, 1, 1, "R5 zero count", 1'b0);
        // R5 edge count above reference
        run(300000000, 1, 1, 10000000, 1, 1, "R5 ni zero", 1'b0);
        // R6 leftover not below Ni
        run(10000000, 30, 30, 10000000, 1, 1, "R6 overflow", 1'b0);
        // Clean run after a fault
        run(9999999, 7, 8, 10000001, 20, 6, "R2 R3 recover", 1'b0);
        // R7 start in the middle of a run
        run(5000000, 40, 30, 5000000, 10, 11, "R7 mid", 1'b1);

        // R7 start in the same cycle as done
        begin
            exp_t e;
            e = build(8000000, 20, 20, 8000000, 5, 5, "R7 collide");
            sb.push_back(e);
            @(negedge clk);
            drive(8000000, 20, 20, 8000000, 5, 5);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            while (!done_o) @(negedge clk);
            drive(4000000, 9, 9, 2000000, 1, 1);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (300) @(negedge clk);
            check(busy_o == 1'b0, "R7", "start on done dropped", busy_o, 0);
            check(sb.size() == 0, "R7", "scoreboard drained", sb.size(), 0);
        end

        // Accepted again once idle
        run(4000000, 9, 9, 2000000, 1, 1, "R3 R4 after collide", 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule